// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block is the digital mode sequencer of a bus transceiver node. It has five operating modes: unpowered, pre-normal, normal, silent and sleep. The mode decides whether the local regulator runs and at which tolerance, whether the bus driver may transmit, and whether the slave termination is connected. The analog front end supplies its results as digital flags: supply good, supply lost, regulator undervoltage and a bus wake-up that has already been filtered. A host microcontroller steers the block through two pins, enable and transmit data. The block drives an active-low reset output back to that host.

Timing comes from a 1 MHz tick enable (`tick_en`), so every delay is counted in microseconds and does not depend on the system clock. The block samples the enable and transmit pins through two-flop synchronisers. Enable drives mode changes and is ignored while the reset output is low. At a falling edge of enable, the level of the transmit pin decides which low-power mode the block enters. Undervoltage and wake-up events always return the block to pre-normal, never directly to normal.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: When `supply_ok` is high in unpowered mode and `supply_lost` is low, the block enters pre-normal on the next clock edge, whatever the enable level. In pre-normal the outputs {reg_on, reg_wide_tol, comm_en, term_en, nres} are 1,0,0,1 and reset-dependent. In unpowered mode all five outputs are 0.
- R2: Once the regulator is on and `vcc_uv` is low, `nres` stays low for RESET_US ticks. It rises on the clock edge that counts the last of those ticks. Cycles with `tick_en` low are not counted.
- R3: While `nres` is low, enable activity causes no mode change. A high enable level in pre-normal or in sleep therefore leaves the outputs unchanged.
- R4: In pre-normal, with `nres` high, a high synchronised enable moves the block to normal. The enable pin takes three clock edges to reach the mode. Normal drives the outputs to 1,0,1,1,1.
- R5: In normal, a synchronised falling edge of enable while transmit is high selects silent mode. This takes three edges from the pin change. Silent drives the outputs to 1,1,0,0,1.
- R6: In normal, a synchronised falling edge of enable while transmit is low selects sleep mode. This takes three edges. Sleep drives all outputs to 0.
- R7: In silent, a high synchronised enable moves the block straight to normal. This takes three edges.
- R8: `bus_wake` in silent or sleep moves the block to pre-normal on the next edge. Termination turns back on. Coming from sleep, the regulator turns on and a new reset hold starts.
- R9: `vcc_uv` held high for DEBOUNCE_US ticks in pre-normal, normal or silent pulls `nres` low and leaves the block in pre-normal, on the edge that counts the last tick. A shorter pulse has no effect.
- R10: `supply_lost` moves the block from any mode to unpowered on the next edge. While it stays high, it takes priority over `supply_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 1 MHz; time base for all delays |
| supply_ok | input | 1 | Battery supply above its start threshold |
| supply_lost | input | 1 | Battery supply below its loss threshold |
| vcc_uv | input | 1 | Regulator output below its undervoltage threshold |
| en_pin | input | 1 | Host enable pin, asynchronous |
| txd_pin | input | 1 | Host transmit data pin, asynchronous |
| bus_wake | input | 1 | Filtered remote wake-up request from the bus |
| reg_on | output | 1 | Regulator enable |
| reg_wide_tol | output | 1 | Regulator in its relaxed-tolerance low-power setting |
| comm_en | output | 1 | Bus transmit/receive path enable |
| term_en | output | 1 | Slave termination resistor enable |
| nres | output | 1 | Active-low reset to the host |

## Verification
Two situations are hard to reach from the ports. The first is a reset hold that has to restart after waking from sleep while the tick enable is stalled. The second is an undervoltage that arrives in silent mode rather than in normal. The bench runs with a 20-tick hold and a 3-tick debounce. It walks the block through normal, silent, sleep and back using pin sequences only. It stops `tick_en` across the wake-up to show that the hold freezes, then restarts it and checks the exact edge on which reset releases. It also sends an undervoltage pulse one tick shorter than the debounce next to a full-length one, so both sides of the threshold are checked.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_PRE    = 3'd1,
    M_NORM   = 3'd2,
    M_SILENT = 3'd3,
    M_SLEEP  = 3'd4
  } mode_e;
endpackage

// File: rtl/xcvr_pin_sync.sv
module xcvr_pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xcvr_hold_timer.sv
module xcvr_hold_timer #(
  parameter int RESET_US    = 10000,
  parameter int DEBOUNCE_US = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic reg_on,
  input  logic vcc_uv,
  output logic hold_done,
  output logic uv_event
);
  localparam int HW = $clog2(RESET_US + 1);
  localparam int DW = $clog2(DEBOUNCE_US + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RESET_US - 1);
  localparam logic [DW-1:0] DB_LAST   = DW'(DEBOUNCE_US - 1);
  localparam logic [DW-1:0] DB_SAT    = DW'(DEBOUNCE_US);

  logic [HW-1:0] hold_cnt;
  logic [DW-1:0] uv_cnt;

  // fires once, on the tick that completes the debounce window
  assign uv_event = reg_on && vcc_uv && tick && (uv_cnt == DB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_cnt    <= '0;
      hold_cnt  <= '0;
      hold_done <= 1'b0;
    end else begin
      if (!reg_on || !vcc_uv)
        uv_cnt <= '0;
      else if (tick && uv_cnt != DB_SAT)
        uv_cnt <= uv_cnt + 1'b1;

      if (!reg_on || uv_event) begin
        hold_cnt  <= '0;
        hold_done <= 1'b0;
      end else if (!hold_done && !vcc_uv && tick) begin
        if (hold_cnt == HOLD_LAST) begin
          hold_cnt  <= '0;
          hold_done <= 1'b1;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  supply_ok,
  input  logic  supply_lost,
  input  logic  en_s,
  input  logic  txd_s,
  input  logic  bus_wake,
  input  logic  uv_event,
  input  logic  hold_done,
  output mode_e mode,
  output logic  reg_on,
  output logic  reg_wide_tol,
  output logic  comm_en,
  output logic  term_en
);
  logic  en_d;
  logic  en_fall;
  mode_e nxt;

  assign en_fall = en_d && !en_s;

  always_comb begin
    nxt = mode;
    if (supply_lost) begin
      nxt = M_OFF;
    end else begin
      unique case (mode)
        M_OFF:    if (supply_ok) nxt = M_PRE;
        M_PRE:    if (en_s && hold_done) nxt = M_NORM;
        M_NORM: begin
          if (uv_event)                    nxt = M_PRE;
          else if (hold_done && en_fall)   nxt = txd_s ? M_SILENT : M_SLEEP;
        end
        M_SILENT: begin
          if (uv_event || bus_wake)        nxt = M_PRE;
          else if (en_s && hold_done)      nxt = M_NORM;
        end
        M_SLEEP:  if (bus_wake) nxt = M_PRE;
        default:  nxt = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF;
      en_d <= 1'b0;
    end else begin
      mode <= nxt;
      en_d <= en_s;
    end
  end

  always_comb begin
    reg_on       = 1'b0;
    reg_wide_tol = 1'b0;
    comm_en      = 1'b0;
    term_en      = 1'b0;
    unique case (mode)
      M_PRE:    begin reg_on = 1'b1; term_en = 1'b1; end
      M_NORM:   begin reg_on = 1'b1; term_en = 1'b1; comm_en = 1'b1; end
      M_SILENT: begin reg_on = 1'b1; reg_wide_tol = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int RESET_US    = 10000,
  parameter int DEBOUNCE_US = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic supply_lost,
  input  logic vcc_uv,
  input  logic en_pin,
  input  logic txd_pin,
  input  logic bus_wake,
  output logic reg_on,
  output logic reg_wide_tol,
  output logic comm_en,
  output logic term_en,
  output logic nres
);
  logic [1:0] pins_s;
  logic       hold_done;
  logic       uv_event;
  mode_e      mode;

  xcvr_pin_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({en_pin, txd_pin}),
    .q     (pins_s)
  );

  xcvr_hold_timer #(
    .RESET_US    (RESET_US),
    .DEBOUNCE_US (DEBOUNCE_US)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .reg_on    (reg_on),
    .vcc_uv    (vcc_uv),
    .hold_done (hold_done),
    .uv_event  (uv_event)
  );

  xcvr_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .supply_lost  (supply_lost),
    .en_s         (pins_s[1]),
    .txd_s        (pins_s[0]),
    .bus_wake     (bus_wake),
    .uv_event     (uv_event),
    .hold_done    (hold_done),
    .mode         (mode),
    .reg_on       (reg_on),
    .reg_wide_tol (reg_wide_tol),
    .comm_en      (comm_en),
    .term_en      (term_en)
  );

  assign nres = hold_done && reg_on;
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk
  import xcvr_mode_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  tick_en,
  input logic  supply_lost,
  input logic  uv_event,
  input mode_e mode,
  input logic  reg_on,
  input logic  reg_wide_tol,
  input logic  comm_en,
  input logic  term_en,
  input logic  nres
);
  p_sleep_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP) |-> (!reg_on && !nres && !term_en));

  p_comm_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    comm_en |-> (nres && term_en && !reg_wide_tol));

  p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRE && !nres) |=> (mode != M_NORM));

  p_loss_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lost |=> (mode == M_OFF && !reg_on && !nres));

  p_uv_to_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_event && (mode == M_NORM || mode == M_SILENT)) |=> (mode == M_PRE && !nres));

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nres) |-> $past(tick_en));

  p_wide_only_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wide_tol |-> (reg_on && !comm_en && !term_en));
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .supply_lost  (supply_lost),
  .uv_event     (uv_event),
  .mode         (mode),
  .reg_on       (reg_on),
  .reg_wide_tol (reg_wide_tol),
  .comm_en      (comm_en),
  .term_en      (term_en),
  .nres         (nres)
);

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int RH    = 20;
  localparam int DB    = 3;

  // expected {reg_on, reg_wide_tol, comm_en, term_en, nres}
  localparam logic [4:0] O_OFF  = 5'b00000;
  localparam logic [4:0] O_HOLD = 5'b10010;
  localparam logic [4:0] O_PRE  = 5'b10011;
  localparam logic [4:0] O_NORM = 5'b10111;
  localparam logic [4:0] O_SIL  = 5'b11001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic supply_ok = 1'b0;
  logic supply_lost = 1'b0;
  logic vcc_uv = 1'b0;
  logic en_pin = 1'b0;
  logic txd_pin = 1'b1;
  logic bus_wake = 1'b0;
  logic reg_on, reg_wide_tol, comm_en, term_en, nres;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xcvr_mode_ctrl #(.RESET_US(RH), .DEBOUNCE_US(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_ok(supply_ok),
    .supply_lost(supply_lost), .vcc_uv(vcc_uv), .en_pin(en_pin),
    .txd_pin(txd_pin), .bus_wake(bus_wake), .reg_on(reg_on),
    .reg_wide_tol(reg_wide_tol), .comm_en(comm_en), .term_en(term_en),
    .nres(nres)
  );

  task automatic go(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input string what, input logic [4:0] exp);
    logic [4:0] act;
    act = {reg_on, reg_wide_tol, comm_en, term_en, nres};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: outputs %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    go(3);
    rst_n = 1'b1;
    go(1);
    expect_out("R10", "reset state unpowered", O_OFF);

    // R1: enable alone does not leave unpowered
    en_pin = 1'b1;
    go(5);
    expect_out("R1", "no supply stays unpowered", O_OFF);

    // R1/R2/R3/R4: power up with enable already high
    supply_ok = 1'b1;
    go(1);
    expect_out("R1", "enters pre-normal", O_HOLD);
    go(RH - 1);
    expect_out("R3", "enable ignored during hold", O_HOLD);
    go(1);
    expect_out("R2", "reset released after hold", O_PRE);
    go(1);
    expect_out("R4", "pre-normal to normal", O_NORM);

    // R5: fall with txd high
    txd_pin = 1'b1; en_pin = 1'b0;
    go(2);
    expect_out("R5", "two edges still normal", O_NORM);
    go(1);
    expect_out("R5", "silent selected", O_SIL);

    // R7: silent back to normal
    en_pin = 1'b1;
    go(2);
    expect_out("R7", "two edges still silent", O_SIL);
    go(1);
    expect_out("R7", "silent to normal", O_NORM);

    // R9: glitch then full undervoltage in normal
    vcc_uv = 1'b1;
    go(DB - 1);
    vcc_uv = 1'b0;
    go(1);
    expect_out("R9", "short undervoltage ignored", O_NORM);
    vcc_uv = 1'b1;
    go(DB - 1);
    expect_out("R9", "one tick before debounce", O_NORM);
    go(1);
    expect_out("R9", "undervoltage to pre-normal", O_HOLD);
    go(4);
    expect_out("R9", "reset held during undervoltage", O_HOLD);
    vcc_uv = 1'b0;
    go(RH);
    expect_out("R2", "hold after undervoltage", O_PRE);
    go(1);
    expect_out("R4", "back to normal", O_NORM);

    // R9 in silent
    txd_pin = 1'b1; en_pin = 1'b0;
    go(3);
    expect_out("R5", "silent again", O_SIL);
    vcc_uv = 1'b1;
    go(DB);
    expect_out("R9", "silent undervoltage to pre-normal", O_HOLD);
    vcc_uv = 1'b0;
    go(RH + 2);
    expect_out("R9", "stays pre-normal with enable low", O_PRE);
    en_pin = 1'b1;
    go(3);
    expect_out("R4", "normal from pre-normal", O_NORM);

    // R8: wake from silent
    en_pin = 1'b0;
    go(3);
    expect_out("R5", "silent for wake", O_SIL);
    bus_wake = 1'b1;
    go(1);
    expect_out("R8", "silent wake to pre-normal", O_PRE);
    bus_wake = 1'b0;
    go(3);
    expect_out("R8", "remains pre-normal", O_PRE);

    // R6: fall with txd low
    en_pin = 1'b1;
    go(3);
    expect_out("R4", "normal before sleep", O_NORM);
    txd_pin = 1'b0; en_pin = 1'b0;
    go(2);
    expect_out("R6", "two edges still normal", O_NORM);
    go(1);
    expect_out("R6", "sleep selected", O_OFF);
    en_pin = 1'b1;
    go(5);
    expect_out("R3", "enable ignored in sleep", O_OFF);
    en_pin = 1'b0; txd_pin = 1'b1;
    go(3);
    expect_out("R6", "sleep persists", O_OFF);

    // R8/R2: wake from sleep with stalled tick
    tick_en = 1'b0;
    bus_wake = 1'b1;
    go(1);
    expect_out("R8", "sleep wake turns regulator on", O_HOLD);
    bus_wake = 1'b0;
    go(RH + 5);
    expect_out("R2", "hold frozen without tick", O_HOLD);
    tick_en = 1'b1;
    go(RH - 1);
    expect_out("R2", "one tick before release", O_HOLD);
    go(1);
    expect_out("R2", "released after counted ticks", O_PRE);

    // R10: loss from normal and from silent
    en_pin = 1'b1;
    go(3);
    expect_out("R4", "normal before loss", O_NORM);
    supply_lost = 1'b1;
    go(1);
    expect_out("R10", "loss from normal", O_OFF);
    go(3);
    expect_out("R10", "loss wins over supply good", O_OFF);
    supply_lost = 1'b0;
    go(1);
    expect_out("R1", "re-entry to pre-normal", O_HOLD);
    go(RH + 1);
    expect_out("R4", "normal after re-entry", O_NORM);
    en_pin = 1'b0;
    go(3);
    expect_out("R5", "silent before loss", O_SIL);
    supply_lost = 1'b1;
    go(1);
    expect_out("R10", "loss from silent", O_OFF);
    supply_lost = 1'b0; supply_ok = 1'b0;
    go(3);
    expect_out("R10", "unpowered without supply", O_OFF);

    finish_run();
  end
endmodule